// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block is a synchronous serial slave that sets up an analog front end. A host sends 16-bit command frames on a single data-in pin. Each bit is clocked by a serial clock and the whole frame is framed by an active-high frame-enable strobe. Each frame carries a read/write flag, a bank select and a 12-bit payload. A write updates one of three functional banks: a control word, a transmit filter corner word or a receive filter corner word. When a filter bank is written with its dual flag set, the same corner word goes into both filter registers in one frame.

A read copies the addressed bank into an output register. The bank's bits are then returned on a data-return pin during the next frame, while an output-enable marks the bits being driven. The control word is presented in parallel. Two enables are derived from it: one for the line driver amplifier and one for the transmit filter amplifier.

The block runs directly on the serial clock. Bits are captured on the rising edge and returned on the falling edge. An asynchronous active-low reset brings every bank back to a known state.

Top module: `cfg_serial_if`

## Requirements
- R1: A frame is 16 bits sent MSB first, one bit per rising serClk edge while frameEn is high. Frame bit 15 is the read/write flag (0 = write), bits 14:12 are the bank select and bits 11:0 are the payload. A write with select 000 loads the payload into ctrlWord, which is visible after the 16th rising edge.
- R2: A write with select 001 loads payload bits 10:0 into txFiltWord. When payload bit 11 is 0, rxFiltWord is unchanged.
- R3: A write with select 010 loads payload bits 10:0 into rxFiltWord. When payload bit 11 is 0, txFiltWord is unchanged.
- R4: A write with select 001 or 010 and payload bit 11 set loads payload bits 10:0 into both txFiltWord and rxFiltWord.
- R5: Write frames with select 011 (test) or 100 to 111 leave ctrlWord, txFiltWord and rxFiltWord unchanged.
- R6: A frame whose strobe drops before 16 bits are sent is discarded. Bits sent after the 16th bit of a frame are ignored. A discarded frame does not disturb the decoding of the next frame.
- R7: A read frame (bit 15 = 1) changes no register. In the next frame, the addressed bank is returned as 12 bits, MSB first. Each bit is driven on sdoBit at the falling edge that follows rising edges 1 to 12 of that frame. Select 000 returns ctrlWord, select 001 and 010 return {0, filter word}, and every other select returns zero.
- R8: sdoEn is high only in the 12 return slots of the frame that follows a read. At every other time it is low, which means the return pin is released.
- R9: ctrlWord fields: bit 0 transmit power on, bit 1 receive power on, bit 2 analog loopback, bit 3 ADC buffer bypass, bit 4 receive filter bypass, bit 5 transmit 6 dB attenuate, bit 6 DAC-out select, bit 7 transmit filter bypass, bit 8 line driver bypass, bits 11:9 PGA gain code. The reset value is 12'h003.
- R10: lineDrvEn = transmit power on AND NOT DAC-out select AND NOT line driver bypass. txFiltAmpEn = transmit power on AND NOT transmit filter bypass.
- R11: When rstN goes low, the block resets immediately, without waiting for a clock edge. ctrlWord becomes 12'h003, both filter words become zero, and any pending read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serClk | input | 1 | Serial clock; capture on rise, return on fall |
| rstN | input | 1 | Asynchronous active-low reset |
| frameEn | input | 1 | Frame strobe, active high |
| sdi | input | 1 | Serial command data in, MSB first |
| sdoBit | output | 1 | Serial read-back data |
| sdoEn | output | 1 | High while sdoBit is driven; low means released |
| ctrlWord | output | 12 | Control register fields |
| txFiltWord | output | 11 | Transmit filter corner word |
| rxFiltWord | output | 11 | Receive filter corner word |
| lineDrvEn | output | 1 | Line driver amplifier output enable |
| txFiltAmpEn | output | 1 | Transmit filter amplifier output enable |

## Verification
Some rules are checked by assertions on every serial clock cycle. The bit counter never runs past a full frame, and it returns to zero when the strobe drops. The control word holds unless a control write strobe fires, and a read strobe leaves every bank untouched. A single-bank filter write leaves the other filter alone, and a dual write leaves both filters equal. The return enable is never high without a pending read.

Other behaviour needs a full frame sequence, so only the bench scenarios show it. These scenarios cover:
- the exact bit order and falling-edge slot timing of the read-back;
- the values returned for each bank;
- the discarding of short frames and of extra bits;
- the reserved selects;
- the driver enable decode;
- the asynchronous reset arriving between clock edges.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  localparam int BANK_W = 3;

  typedef enum logic [BANK_W-1:0] {
    BANK_CTRL = 3'b000,
    BANK_TXF  = 3'b001,
    BANK_RXF  = 3'b010,
    BANK_TEST = 3'b011
  } bank_e;

  // Control word field positions (R9)
  localparam int CB_TXPWR   = 0;
  localparam int CB_RXPWR   = 1;
  localparam int CB_LOOP    = 2;
  localparam int CB_ADCBYP  = 3;
  localparam int CB_RXFBYP  = 4;
  localparam int CB_TXATT   = 5;
  localparam int CB_DACOUT  = 6;
  localparam int CB_TXFBYP  = 7;
  localparam int CB_DRVBYP  = 8;
  localparam int CB_PGA_LSB = 9;
  localparam int PGA_W      = 3;

  localparam logic [11:0] CTRL_RESET = 12'h003;

  // Strobes from control to datapath
  typedef struct packed {
    logic              shiftEn;
    logic              wrCtrl;
    logic              wrTx;
    logic              wrRx;
    logic              loadRead;
    logic              rdSlot;
    logic [BANK_W-1:0] readSel;
  } strobe_t;

endpackage

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_serial_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int PAY_W   = 12
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              frameEn,
  input  logic              hdrRw,
  input  logic [BANK_W-1:0] hdrSel,
  input  logic              hdrDual,
  output strobe_t           stb,
  output logic              readPending
);

  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0] bitCnt;
  logic             frameFull;
  logic             lastBit;

  assign lastBit = frameEn && !frameFull && (bitCnt == CNT_W'(FRAME_W - 1));

  always_comb begin
    stb         = '0;
    stb.shiftEn = frameEn && !frameFull;
    stb.rdSlot  = frameEn && !frameFull && readPending;
    stb.readSel = hdrSel;
    if (lastBit) begin
      if (hdrRw) begin
        stb.loadRead = 1'b1;
      end else begin
        case (bank_e'(hdrSel))
          BANK_CTRL: stb.wrCtrl = 1'b1;
          BANK_TXF: begin
            stb.wrTx = 1'b1;
            stb.wrRx = hdrDual;
          end
          BANK_RXF: begin
            stb.wrRx = 1'b1;
            stb.wrTx = hdrDual;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      frameFull <= 1'b0;
    end else if (!frameEn) begin
      bitCnt    <= '0;
      frameFull <= 1'b0;
    end else if (!frameFull) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) begin
        frameFull <= 1'b1;
      end
    end
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      readPending <= 1'b0;
    end else if (stb.loadRead) begin
      readPending <= 1'b1;
    end else if (frameEn && readPending && bitCnt == CNT_W'(PAY_W)) begin
      readPending <= 1'b0;
    end
  end

  // R6
  bit_cnt_bound_chk: assert property (@(posedge serClk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));

  // R6
  abort_clears_cnt_chk: assert property (@(posedge serClk) disable iff (!rstN)
    !frameEn |=> (bitCnt == '0) && !frameFull);

endmodule

// File: rtl/cfg_serial_dpath.sv
module cfg_serial_dpath
  import cfg_serial_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int PAY_W   = 12,
  parameter int FILT_W  = 11
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              frameEn,
  input  logic              sdi,
  input  strobe_t           stb,
  output logic              hdrRw,
  output logic [BANK_W-1:0] hdrSel,
  output logic              hdrDual,
  output logic [PAY_W-1:0]  ctrlReg,
  output logic [FILT_W-1:0] txFilt,
  output logic [FILT_W-1:0] rxFilt,
  output logic              sdoBit,
  output logic              sdoEn
);

  localparam int IDX_W = $clog2(PAY_W + 1);
  localparam int PAD_W = PAY_W - FILT_W;

  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] frameWord;
  logic [PAY_W-1:0]   readMux;
  logic [PAY_W-1:0]   outReg;
  logic [PAY_W-1:0]   outView;
  logic [IDX_W-1:0]   outIdx;

  assign frameWord = {shiftReg, sdi};
  assign hdrRw     = frameWord[FRAME_W-1];
  assign hdrSel    = frameWord[PAY_W +: BANK_W];
  assign hdrDual   = frameWord[PAY_W-1];

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.shiftEn) begin
      shiftReg <= frameWord[FRAME_W-2:0];
    end
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= PAY_W'(CTRL_RESET);
      txFilt  <= '0;
      rxFilt  <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= frameWord[PAY_W-1:0];
      if (stb.wrTx)   txFilt  <= frameWord[FILT_W-1:0];
      if (stb.wrRx)   rxFilt  <= frameWord[FILT_W-1:0];
    end
  end

  always_comb begin
    case (bank_e'(stb.readSel))
      BANK_CTRL: readMux = ctrlReg;
      BANK_TXF:  readMux = {{PAD_W{1'b0}}, txFilt};
      BANK_RXF:  readMux = {{PAD_W{1'b0}}, rxFilt};
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (stb.loadRead) begin
      outReg <= readMux;
    end
  end

  assign outView = outReg << outIdx;

  always_ff @(negedge serClk or negedge rstN) begin
    if (!rstN) begin
      outIdx <= '0;
      sdoBit <= 1'b0;
      sdoEn  <= 1'b0;
    end else if (!frameEn) begin
      outIdx <= '0;
      sdoEn  <= 1'b0;
    end else if (stb.rdSlot && outIdx < IDX_W'(PAY_W)) begin
      sdoBit <= outView[PAY_W-1];
      sdoEn  <= 1'b1;
      outIdx <= outIdx + 1'b1;
    end else begin
      sdoEn <= 1'b0;
    end
  end

  // R1
  ctrl_hold_chk: assert property (@(posedge serClk) disable iff (!rstN)
    !stb.wrCtrl |=> $stable(ctrlReg));

  // R2
  tx_only_keeps_rx_chk: assert property (@(posedge serClk) disable iff (!rstN)
    (stb.wrTx && !stb.wrRx) |=> $stable(rxFilt));

  // R3
  rx_only_keeps_tx_chk: assert property (@(posedge serClk) disable iff (!rstN)
    (stb.wrRx && !stb.wrTx) |=> $stable(txFilt));

  // R4
  dual_equal_chk: assert property (@(posedge serClk) disable iff (!rstN)
    (stb.wrTx && stb.wrRx) |=> (txFilt == rxFilt));

  // R7
  read_no_write_chk: assert property (@(posedge serClk) disable iff (!rstN)
    stb.loadRead |=> $stable(ctrlReg) && $stable(txFilt) && $stable(rxFilt));

endmodule

// File: rtl/cfg_serial_if.sv
module cfg_serial_if
  import cfg_serial_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int PAY_W   = 12,
  parameter int FILT_W  = 11
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              frameEn,
  input  logic              sdi,
  output logic              sdoBit,
  output logic              sdoEn,
  output logic [PAY_W-1:0]  ctrlWord,
  output logic [FILT_W-1:0] txFiltWord,
  output logic [FILT_W-1:0] rxFiltWord,
  output logic              lineDrvEn,
  output logic              txFiltAmpEn
);

  strobe_t           stb;
  logic              readPending;
  logic              hdrRw;
  logic [BANK_W-1:0] hdrSel;
  logic              hdrDual;

  cfg_serial_ctrl #(
    .FRAME_W(FRAME_W),
    .PAY_W  (PAY_W)
  ) ctrl_i (
    .serClk     (serClk),
    .rstN       (rstN),
    .frameEn    (frameEn),
    .hdrRw      (hdrRw),
    .hdrSel     (hdrSel),
    .hdrDual    (hdrDual),
    .stb        (stb),
    .readPending(readPending)
  );

  cfg_serial_dpath #(
    .FRAME_W(FRAME_W),
    .PAY_W  (PAY_W),
    .FILT_W (FILT_W)
  ) dpath_i (
    .serClk (serClk),
    .rstN   (rstN),
    .frameEn(frameEn),
    .sdi    (sdi),
    .stb    (stb),
    .hdrRw  (hdrRw),
    .hdrSel (hdrSel),
    .hdrDual(hdrDual),
    .ctrlReg(ctrlWord),
    .txFilt (txFiltWord),
    .rxFilt (rxFiltWord),
    .sdoBit (sdoBit),
    .sdoEn  (sdoEn)
  );

  assign lineDrvEn   = ctrlWord[CB_TXPWR] & ~ctrlWord[CB_DACOUT] & ~ctrlWord[CB_DRVBYP];
  assign txFiltAmpEn = ctrlWord[CB_TXPWR] & ~ctrlWord[CB_TXFBYP];

  // R8
  sdo_needs_pending_chk: assert property (@(posedge serClk) disable iff (!rstN)
    sdoEn |-> readPending);

endmodule

// File: tb/cfg_serial_if_tb.sv
`timescale 1ns/1ps
module cfg_serial_if_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameEn = 1'b0;
  logic        sdi = 1'b0;
  logic        sdoBit;
  logic        sdoEn;
  logic [11:0] ctrlWord;
  logic [10:0] txFiltWord;
  logic [10:0] rxFiltWord;
  logic        lineDrvEn;
  logic        txFiltAmpEn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_if dut_i (
    .serClk     (clk),
    .rstN       (rstN),
    .frameEn    (frameEn),
    .sdi        (sdi),
    .sdoBit     (sdoBit),
    .sdoEn      (sdoEn),
    .ctrlWord   (ctrlWord),
    .txFiltWord (txFiltWord),
    .rxFiltWord (rxFiltWord),
    .lineDrvEn  (lineDrvEn),
    .txFiltAmpEn(txFiltAmpEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkRegs(input logic [11:0] c, input logic [10:0] t,
                         input logic [10:0] r, input string req);
    chk(ctrlWord == c, {req, " ctrlWord"}, ctrlWord, c);
    chk(txFiltWord == t, {req, " txFiltWord"}, txFiltWord, t);
    chk(rxFiltWord == r, {req, " rxFiltWord"}, rxFiltWord, r);
  endtask

  task automatic sendFrame(input logic [15:0] w, input int nbits,
                           output logic [11:0] rd, output int enCnt, output int lateEn);
    rd = '0;
    enCnt = 0;
    lateEn = 0;
    @(negedge clk); #1;
    frameEn = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      @(posedge clk);
      @(negedge clk); #1;
      if (sdoEn) begin
        if (i < 12) enCnt++;
        else lateEn++;
      end
      if (i < 12) rd[11-i] = sdoBit;
    end
    frameEn = 1'b0;
    sdi = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] w);
    logic [11:0] rd;
    int e, l;
    sendFrame(w, 16, rd, e, l);
  endtask

  task automatic testReset();
    // R9 R11 R8 R10 reset state
    chkRegs(12'h003, 11'h000, 11'h000, "R9_R11 reset");
    chk(sdoEn == 1'b0, "R8 reset sdoEn", sdoEn, 0);
    chk(lineDrvEn == 1'b1, "R10 reset lineDrvEn", lineDrvEn, 1);
    chk(txFiltAmpEn == 1'b1, "R10 reset txFiltAmpEn", txFiltAmpEn, 1);
  endtask

  task automatic testCtrlWrite();
    wr(16'h0E3C);
    chk(ctrlWord == 12'hE3C, "R1 ctrl write E3C", ctrlWord, 12'hE3C);
    wr(16'h0555);
    chk(ctrlWord == 12'h555, "R1 ctrl write 555", ctrlWord, 12'h555);
  endtask

  task automatic testFilterWrites();
    wr(16'h17A5);
    chkRegs(12'h555, 11'h7A5, 11'h000, "R2 tx single");
    wr(16'h2312);
    chkRegs(12'h555, 11'h7A5, 11'h312, "R3 rx single");
  endtask

  task automatic testDual();
    wr(16'h2ABC);
    chkRegs(12'h555, 11'h2BC, 11'h2BC, "R4 dual via rx");
    wr(16'h1C01);
    chkRegs(12'h555, 11'h401, 11'h401, "R4 dual via tx");
  endtask

  task automatic testReserved();
    wr(16'h3FFF);
    chkRegs(12'h555, 11'h401, 11'h401, "R5 test bank");
    wr(16'h4FFF);
    wr(16'h7123);
    chkRegs(12'h555, 11'h401, 11'h401, "R5 unused banks");
  endtask

  task automatic testFraming();
    logic [11:0] rd;
    int e, l;
    sendFrame(16'h0FFF, 10, rd, e, l);
    chk(ctrlWord == 12'h555, "R6 short frame discarded", ctrlWord, 12'h555);
    wr(16'h0123);
    chk(ctrlWord == 12'h123, "R6 frame after abort", ctrlWord, 12'h123);
    sendFrame(16'h0456, 20, rd, e, l);
    chk(ctrlWord == 12'h456, "R6 extra bits ignored", ctrlWord, 12'h456);
  endtask

  task automatic readBank(input logic [15:0] cmd, input logic [15:0] nextCmd,
                          input logic [11:0] exp, input string req);
    logic [11:0] rd;
    int e, l;
    sendFrame(cmd, 16, rd, e, l);
    chk(e == 0 && l == 0, {req, " sdoEn idle in read frame R8"}, e + l, 0);
    sendFrame(nextCmd, 16, rd, e, l);
    chk(rd == exp, {req, " data"}, rd, exp);
    chk(e == 12, {req, " R8 enable slots"}, e, 12);
    chk(l == 0, {req, " R8 released after slots"}, l, 0);
  endtask

  task automatic testReadBack();
    logic [11:0] rd;
    int e, l;
    readBank(16'h8000, 16'h3000, 12'h456, "R7 ctrl read");
    chkRegs(12'h456, 11'h401, 11'h401, "R7 read no side effect");
    readBank(16'h9000, 16'h3000, 12'h401, "R7 tx read");
    wr(16'h2155);
    readBank(16'hA000, 16'h3000, 12'h155, "R7 rx read");
    readBank(16'hB000, 16'h3000, 12'h000, "R7 test bank read");
    readBank(16'h8000, 16'h0003, 12'h456, "R7 read then write");
    chk(ctrlWord == 12'h003, "R1 write in return frame", ctrlWord, 12'h003);
    sendFrame(16'h3000, 16, rd, e, l);
    chk(e + l == 0, "R8 no pending read", e + l, 0);
  endtask

  task automatic testDriverGate();
    wr(16'h0003);
    chk({lineDrvEn, txFiltAmpEn} == 2'b11, "R10 default", {lineDrvEn, txFiltAmpEn}, 2'b11);
    wr(16'h0002);
    chk({lineDrvEn, txFiltAmpEn} == 2'b00, "R10 tx off", {lineDrvEn, txFiltAmpEn}, 2'b00);
    wr(16'h0043);
    chk({lineDrvEn, txFiltAmpEn} == 2'b01, "R10 dac out", {lineDrvEn, txFiltAmpEn}, 2'b01);
    wr(16'h0083);
    chk({lineDrvEn, txFiltAmpEn} == 2'b10, "R10 filt bypass", {lineDrvEn, txFiltAmpEn}, 2'b10);
    wr(16'h0103);
    chk({lineDrvEn, txFiltAmpEn} == 2'b01, "R10 drv bypass", {lineDrvEn, txFiltAmpEn}, 2'b01);
  endtask

  task automatic testAsyncReset();
    logic [11:0] rd;
    int e, l;
    wr(16'h07F0);
    wr(16'h10AA);
    sendFrame(16'h8000, 16, rd, e, l);
    @(negedge clk); #1;
    rstN = 1'b0;
    #0.5;
    chkRegs(12'h003, 11'h000, 11'h000, "R11 async reset");
    @(negedge clk); #1;
    rstN = 1'b1;
    sendFrame(16'h3000, 16, rd, e, l);
    chk(e + l == 0, "R11 pending read dropped", e + l, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testCtrlWrite();
    testFilterWrites();
    testDual();
    testReserved();
    testFraming();
    testReadBack();
    testDriverGate();
    testAsyncReset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule